// File: doc/BRIEF.md
# Receiver Automatic Gain Controller

This block picks the attenuation step of a reader's receive amplifier. It is fed by two comparator flags: one says the envelope is above the attack threshold, the other says it is above the decay threshold. A third input marks the interval in which the reader is modulating its own field. The output is a 3-bit attenuation code. Code 0 is maximum gain, and each code step removes about 5.7 dB, so the eight codes span roughly 40 dB.

When the controller is enabled it works as follows. The gain starts at maximum. Each time the attack flag has been high for a programmable number of time-base ticks, the gain drops by one step. The gain holds while the signal sits between the two thresholds. Once the signal has stayed below the decay threshold for a programmable wait, the gain returns to maximum in a single move (fast mode), or climbs back one step per wait period (slow mode). Fast mode readies the receiver for the next, possibly distant, transponder in an anti-collision exchange.

An optional mode leaves the first pulse of a new burst unattacked, so that a DC shift can settle before any gain is removed. When the controller is disabled, the static gain code from configuration is passed straight through. A prescaler divides the system clock into a time base of roughly one microsecond.

Top module: `rx_gain_ctrl`

## Requirements
- R1: With `agc_en_i` low, `gain_o` equals `static_gain_i`. Code 0 is maximum gain. Bit 0 adds about 5.7 dB of attenuation, bit 1 about 11.4 dB and bit 2 about 22.8 dB.
- R2: After reset, and in the cycle after any cycle in which `mod_active_i` is high, an enabled controller outputs code 0.
- R3: While `above_attack_i` is high and attack is permitted, the code rises by one every 2^`attack_rate_i` ticks, and it saturates at 7. One tick is TICK_DIV clock cycles.
- R4: While `above_decay_i` is high and `above_attack_i` is low, the code holds.
- R5: With `slow_decay_i` low, once both flags have been low for WAIT_BASE×2^`decay_wait_i` ticks, the code returns to 0.
- R6: With `slow_decay_i` high, the code falls by one for each full wait period in which both flags stay low, and it saturates at 0.
- R7: With `attack_skip_i` high, the first attack pulse after reset, after modulation or after a decay timeout does not change the code. A later attack pulse does change it.
- R8: Any change of either flag restarts the attack and decay timers. As a result, decay dips that are each shorter than the wait leave the code unchanged.
- R9: Between two consecutive enabled cycles without modulation, the code changes by at most one step, unless it drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| agc_en_i | input | 1 | Enables automatic control |
| static_gain_i | input | 3 | Gain code used while disabled |
| attack_skip_i | input | 1 | Leave the first pulse of a burst unattacked |
| slow_decay_i | input | 1 | 1: one step per wait period; 0: jump to max gain |
| attack_rate_i | input | 2 | Attack step period, 2^n ticks |
| decay_wait_i | input | 2 | Decay wait, WAIT_BASE×2^n ticks |
| mod_active_i | input | 1 | Reader field modulation in progress |
| above_attack_i | input | 1 | Envelope above attack threshold |
| above_decay_i | input | 1 | Envelope above decay threshold |
| gain_o | output | 3 | Attenuation code, 0 = maximum gain |

## Verification
The bench measures the number of cycles between successive attack steps at two rate settings. A design that miscounts the rate divider would show the wrong spacing, and one that does not saturate would wrap from 7 back to 0. It times the fast-decay return and the slow-decay descent against the wait window, which exposes an off-by-one wait or a slow mode that jumps straight to maximum gain. Repeated short dips below the decay threshold catch a decay timer that accumulates across flag changes. A skipped first pulse followed by a second, attacked pulse catches a skip flag that never clears or that never arms.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int unsigned GAIN_W   = 3;
  localparam int unsigned GAIN_MAX = (1 << GAIN_W) - 1;
  typedef logic [GAIN_W-1:0] gain_t;
endpackage

// File: rtl/rxg_prescaler.sv
module rxg_prescaler #(
  parameter int unsigned DIV = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/rxg_interval_timer.sv
module rxg_interval_timer #(
  parameter int unsigned LIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             fire_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == limit_i - 1'b1);
  assign fire_o = run_i & tick_i & last & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
  import rxg_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 14,
  parameter int unsigned WAIT_BASE = 44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              agc_en_i,
  input  logic [GAIN_W-1:0] static_gain_i,
  input  logic              attack_skip_i,
  input  logic              slow_decay_i,
  input  logic [1:0]        attack_rate_i,
  input  logic [1:0]        decay_wait_i,
  input  logic              mod_active_i,
  input  logic              above_attack_i,
  input  logic              above_decay_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned LIM_W = $clog2(WAIT_BASE * 8 + 1) + 1;

  logic  tick;
  logic  att_prev_q, dec_prev_q, first_pend_q;
  gain_t code_q;
  logic  flag_chg, run_ok, attacking, decaying, att_fire, dec_fire;
  logic [LIM_W-1:0] att_lim, dec_lim;

  rxg_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  assign flag_chg  = (above_attack_i != att_prev_q) | (above_decay_i != dec_prev_q);
  assign run_ok    = agc_en_i & ~mod_active_i;
  assign attacking = run_ok & above_attack_i & ~(attack_skip_i & first_pend_q);
  assign decaying  = run_ok & ~above_attack_i & ~above_decay_i;
  assign att_lim   = LIM_W'(1) << attack_rate_i;
  assign dec_lim   = LIM_W'(WAIT_BASE) << decay_wait_i;

  rxg_interval_timer #(.LIM_W(LIM_W)) u_att_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flag_chg | ~attacking),
    .run_i (attacking), .tick_i (tick), .limit_i (att_lim), .fire_o (att_fire)
  );

  rxg_interval_timer #(.LIM_W(LIM_W)) u_dec_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flag_chg | ~decaying),
    .run_i (decaying), .tick_i (tick), .limit_i (dec_lim), .fire_o (dec_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_prev_q <= 1'b0;
      dec_prev_q <= 1'b0;
    end else begin
      att_prev_q <= above_attack_i;
      dec_prev_q <= above_decay_i;
    end
  end

  // arm the first-pulse skip at each burst boundary, clear it when a pulse ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            first_pend_q <= 1'b1;
    else if (!run_ok || dec_fire)           first_pend_q <= 1'b1;
    else if (att_prev_q && !above_attack_i) first_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 code_q <= '0;
    else if (!run_ok)            code_q <= '0;
    else if (att_fire) begin
      if (code_q != gain_t'(GAIN_MAX)) code_q <= code_q + 1'b1;
    end else if (dec_fire) begin
      if (!slow_decay_i)         code_q <= '0;
      else if (code_q != '0)     code_q <= code_q - 1'b1;
    end
  end

  assign gain_o = agc_en_i ? code_q : static_gain_i;
endmodule

// File: rtl/rx_gain_ctrl_chk.sv
module rx_gain_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       agc_en_i,
  input logic       mod_active_i,
  input logic       above_attack_i,
  input logic       above_decay_i,
  input logic [2:0] gain_o
);
  assert_mod_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (agc_en_i && mod_active_i) |=> (!agc_en_i || gain_o == 3'd0));

  assert_one_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (agc_en_i && !mod_active_i && $past(agc_en_i) && !$past(mod_active_i)) |->
      (gain_o == 3'd0 || gain_o == $past(gain_o) ||
       gain_o == $past(gain_o) + 3'd1 || gain_o == $past(gain_o) - 3'd1));

  assert_rise_on_attack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (agc_en_i && $past(agc_en_i) && gain_o > $past(gain_o)) |-> $past(above_attack_i));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (agc_en_i && $past(agc_en_i) && !$past(mod_active_i) &&
     $past(above_decay_i) && !$past(above_attack_i)) |-> $stable(gain_o));

  assert_fall_on_decay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (agc_en_i && $past(agc_en_i) && gain_o < $past(gain_o)) |->
      ($past(mod_active_i) || (!$past(above_decay_i) && !$past(above_attack_i))));
endmodule

bind rx_gain_ctrl rx_gain_ctrl_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .agc_en_i (agc_en_i),
  .mod_active_i (mod_active_i), .above_attack_i (above_attack_i),
  .above_decay_i (above_decay_i), .gain_o (gain_o)
);

// File: tb/rx_gain_ctrl_bench.sv
module rx_gain_ctrl_bench;
  localparam int D = 2;
  localparam int W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, skip = 1'b0, slow = 1'b0, mod = 1'b0, att = 1'b0, dec = 1'b0;
  logic [2:0] stat = 3'd0;
  logic [1:0] rate = 2'd0, dwait = 2'd0;
  logic [2:0] gain;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rx_gain_ctrl #(.TICK_DIV(D), .WAIT_BASE(W)) u_rx_gain_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .agc_en_i (en), .static_gain_i (stat),
    .attack_skip_i (skip), .slow_decay_i (slow), .attack_rate_i (rate),
    .decay_wait_i (dwait), .mod_active_i (mod), .above_attack_i (att),
    .above_decay_i (dec), .gain_o (gain)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles until gain changes, capped
  task automatic wait_chg(input int cap, output int c);
    logic [2:0] g0 = gain;
    c = 0;
    while (gain == g0 && c < cap) begin @(negedge clk); c++; end
  endtask

  task automatic go_max_gain();
    mod = 1'b1; cyc(1); mod = 1'b0; att = 1'b0; dec = 1'b1; cyc(1);
  endtask

  task automatic t_reset();
    chk(gain == 3'd0, "R2 reset", gain, 0);
  endtask

  task automatic t_static();
    en = 1'b0;
    for (int v = 3; v < 8; v += 2) begin
      stat = 3'(v); cyc(1);
      chk(gain == 3'(v), "R1 static pass", gain, v);
    end
    en = 1'b1; cyc(1);
    chk(gain == 3'd0, "R1 re-enable starts max", gain, 0);
  endtask

  task automatic t_attack(input logic [1:0] r);
    int c;
    logic [2:0] prev;
    go_max_gain(); rate = r; skip = 1'b0; att = 1'b1;
    wait_chg(100, c);
    chk(gain == 3'd1, "R3 first step", gain, 1);
    for (int k = 2; k <= 7; k++) begin
      prev = gain;
      wait_chg(100, c);
      chk(c == (D << r), "R3 step interval", c, D << r);
      chk(gain == prev + 3'd1, "R9 single step", gain, prev + 1);
    end
    cyc(4 * (D << r));
    chk(gain == 3'd7, "R3 saturate", gain, 7);
  endtask

  task automatic t_hold();
    att = 1'b0; dec = 1'b1; cyc(3 * W * D);
    chk(gain == 3'd7, "R4 hold", gain, 7);
  endtask

  task automatic t_fast();
    int c;
    slow = 1'b0; dwait = 2'd0; dec = 1'b0;
    wait_chg(200, c);
    chk(c >= (W - 1) * D && c <= W * D + 1, "R5 wait length", c, W * D);
    chk(gain == 3'd0, "R5 fast to max", gain, 0);
    dec = 1'b1;
  endtask

  task automatic t_slow();
    int c;
    t_attack(2'd0);
    att = 1'b0; dec = 1'b1; cyc(2);
    slow = 1'b1; dwait = 2'd1; dec = 1'b0;
    wait_chg(400, c);
    chk(gain == 3'd6, "R6 first slow step", gain, 6);
    for (int k = 5; k >= 0; k--) begin
      wait_chg(400, c);
      chk(c == 2 * W * D, "R6 slow interval", c, 2 * W * D);
      chk(gain == 3'(k), "R6 slow value", gain, k);
    end
    cyc(3 * 2 * W * D);
    chk(gain == 3'd0, "R6 floor", gain, 0);
    slow = 1'b0; dwait = 2'd0; dec = 1'b1;
  endtask

  task automatic t_dip();
    go_max_gain(); rate = 2'd0; att = 1'b1; cyc(3 * D + 1);
    att = 1'b0; dec = 1'b1; cyc(2);
    begin
      logic [2:0] g = gain;
      for (int k = 0; k < 4; k++) begin
        dec = 1'b0; cyc(W * D * 3 / 4); dec = 1'b1; cyc(3);
      end
      chk(gain == g && g != 3'd0, "R8 dips ignored", gain, g);
    end
  endtask

  task automatic t_skip();
    go_max_gain(); skip = 1'b1; rate = 2'd0;
    att = 1'b1; cyc(10 * D);
    chk(gain == 3'd0, "R7 first pulse skipped", gain, 0);
    att = 1'b0; cyc(3);
    att = 1'b1; cyc(4 * D);
    chk(gain >= 3'd2, "R7 second pulse attacked", gain, 2);
    att = 1'b0; skip = 1'b0;
  endtask

  task automatic t_mod();
    chk(gain != 3'd0, "R2 precondition", gain, 1);
    mod = 1'b1; cyc(1);
    chk(gain == 3'd0, "R2 modulation max", gain, 0);
    mod = 1'b0; cyc(1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_static();
    t_attack(2'd0);
    t_hold();
    t_fast();
    t_attack(2'd2);
    t_slow();
    t_dip();
    t_mod();
    t_skip();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule